// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Port

This block is a serial peripheral master that a host drives through four 32-bit registers on a simple synchronous write port with a combinational read path. Software sets the serial clock divider, the clock idle level and the sampling phase in a configuration word. It selects a target device by setting one enable bit per select line in the control word. A write of one byte to the transmit register then starts a single full-duplex byte exchange on one output and one input data line.

The controller only runs in its single-byte, single-line mode. While it shifts, a ready flag in the control word reads low. Software polls that flag and then reads the received byte from the receive register. A flush request bit in the configuration word clears itself. A length-select bit and a queue-enable bit in the configuration word are stored and read back, but they do not change the shifting, which always behaves as one byte per trigger with no queue.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control word reads 0x0000_0002 (ready high, no select enabled), every select output is high, the configuration, transmit and receive words read 0, and the serial clock is low.
- R2: The register index is address bits [3:2]: 0 control, 1 configuration, 2 transmit, 3 receive. The configuration word reads back divider [4:0], length bit 5, phase bit 6, polarity bit 7 and queue-enable bit 17, with every other bit 0 once the flush bit has cleared.
- R3: Control bit 16+n drives select output n low while it is 1 and high while it is 0. Control bit 1 is the ready flag: it is read-only, and writes to it have no effect.
- R4: A transmit write while ready is high starts an exchange. Ready reads low from the cycle after that write until exactly 8·D clock edges after the write edge, and then reads high again.
- R5: The low byte of the accepted transmit write goes out most significant bit first. The 8 bits present on the input line are assembled into receive bits [7:0] at the end of the exchange, and the transmit word reads back that accepted byte.
- R6: The effective divider D is the configuration divider, with 0 and 1 both treated as 2. Each bit takes D input clocks: the serial clock holds its idle level for floor(D/2) clocks and then its active level for D - floor(D/2) clocks.
- R7: Whenever no exchange is running, the serial clock equals configuration bit 7 (0 idles low, 1 idles high).
- R8: With phase bit 6 at 0, the input is sampled on the leading (idle-to-active) edge and the output changes on the trailing edge. With phase at 1, the output changes on the leading edge and the input is sampled on the trailing edge. Each exchange has exactly 8 leading edges.
- R9: Writing configuration bit 9 as 1 makes that bit read 1 for exactly one cycle. It then reads 0.
- R10: A transmit write while ready is low, including one on the very edge where an exchange completes, is ignored. It changes neither the byte sent, the exchange length nor the transmit readback, and it does not start a new exchange. The receive word keeps its old value until the running exchange completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte address of the register; bits [3:2] select it |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data from the master |
| spi_miso | input | 1 | Serial data to the master |
| spi_cs_n | output | NUM_CS | Active-low select lines, one per control enable bit |

## Verification
Two functions can collide in one cycle: a new transmit trigger from the host and the completion of the running exchange. The bench provokes this by counting cycles from the start of a transfer and placing a second transmit write on exactly the 8·D-th edge, where ready is still low. It judges the outcome at the ports. The receive word must hold the first exchange's byte, the transmit readback must keep the first byte, and ready must stay high for the following cycles with no new clock activity. A separate scenario drops a write in the middle of an exchange and checks the byte seen by the bench's slave model and the exchange length.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  // register index = address bits [3:2]
  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_CFG  = 2'd1,
    RSEL_TX   = 2'd2,
    RSEL_RX   = 2'd3
  } rsel_e;

  // control word
  localparam int BIT_READY = 1;
  localparam int BIT_CS0   = 16;
  // configuration word
  localparam int BIT_LEN   = 5;
  localparam int BIT_PHA   = 6;
  localparam int BIT_POL   = 7;
  localparam int BIT_FLUSH = 9;
  localparam int BIT_QUEUE = 17;

  // divider values 0 and 1 fall back to 2 so both halves exist
  function automatic int eff_div(input int presc);
    return (presc < 2) ? 2 : presc;
  endfunction

  // clocks at idle level per bit
  function automatic int lead_len(input int div);
    return div / 2;
  endfunction

  // clocks at active level per bit
  function automatic int trail_len(input int div);
    return div - (div / 2);
  endfunction

endpackage

// File: rtl/spi_lm_clkgen.sv
module spi_lm_clkgen
  import spi_lm_pkg::*;
#(
  parameter int PRESC_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               run,
  input  logic [PRESC_W-1:0] div_in,
  output logic               lead_tick,
  output logic               trail_tick
);

  logic [PRESC_W-1:0] div_l;
  logic [PRESC_W-1:0] cnt;
  logic               half;   // 0: idle-level half, 1: active-level half
  int                 lo_n, hi_n;

  always_comb begin
    lo_n       = lead_len(int'(div_l));
    hi_n       = trail_len(int'(div_l));
    lead_tick  = run && !half && (int'(cnt) == lo_n - 1);
    trail_tick = run &&  half && (int'(cnt) == hi_n - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_l <= PRESC_W'(2);
      cnt   <= '0;
      half  <= 1'b0;
    end else if (start) begin
      div_l <= PRESC_W'(eff_div(int'(div_in)));
      cnt   <= '0;
      half  <= 1'b0;
    end else if (run) begin
      if (lead_tick || trail_tick) begin
        cnt  <= '0;
        half <= ~half;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: the half-period counter never reaches the latched divider
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div_l));

endmodule

// File: rtl/spi_lm_shifter.sv
module spi_lm_shifter
  import spi_lm_pkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx_in,
  input  logic            cpol_cfg,
  input  logic            cpha_cfg,
  input  logic            lead_tick,
  input  logic            trail_tick,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx_out,
  output logic            sclk,
  output logic            mosi
);

  localparam int IDX_W = $clog2(BITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BITS - 1);

  logic [BITS-1:0]  tx_sr, rx_sr;
  logic [IDX_W-1:0] bit_idx;
  logic             act_q;
  logic             cpol_l, cpha_l;
  logic [BITS-1:0]  rx_shifted;

  assign rx_shifted = {rx_sr[BITS-2:0], miso};
  assign done       = busy && trail_tick && (bit_idx == LAST);
  assign rx_out     = cpha_l ? rx_shifted : rx_sr;
  assign sclk       = busy ? (cpol_l ^ act_q) : cpol_cfg;
  assign mosi       = tx_sr[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_idx <= '0;
      act_q   <= 1'b0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      tx_sr   <= tx_in;
      rx_sr   <= '0;
      bit_idx <= '0;
      act_q   <= 1'b0;
      cpol_l  <= cpol_cfg;
      cpha_l  <= cpha_cfg;
    end else if (busy) begin
      if (lead_tick) begin
        act_q <= 1'b1;
        if (!cpha_l)
          rx_sr <= rx_shifted;
        else if (bit_idx != '0)
          tx_sr <= {tx_sr[BITS-2:0], 1'b0};
      end
      if (trail_tick) begin
        act_q <= 1'b0;
        if (cpha_l)
          rx_sr <= rx_shifted;
        else if (bit_idx != LAST)
          tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        if (bit_idx == LAST)
          busy <= 1'b0;
        else
          bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R4: an accepted trigger makes the shifter busy on the next cycle
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R7: the clock is back at its idle half when the exchange ends
  p_idle_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !act_q);

endmodule

// File: rtl/spi_lm_regs.sv
module spi_lm_regs
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int PRESC_W = 5,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               ready,
  input  logic               done,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic               start,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic [PRESC_W-1:0] presc,
  output logic               cpol,
  output logic               cpha,
  output logic [NUM_CS-1:0]  cs_en
);

  rsel_e             sel;
  logic              wr_ctrl, wr_cfg, wr_tx;
  logic              len_q, queue_q, flush_q;
  logic [BYTE_W-1:0] din_q;
  logic              unused_bits;

  assign sel         = rsel_e'(addr[3:2]);
  assign wr_ctrl     = wr && (sel == RSEL_CTRL);
  assign wr_cfg      = wr && (sel == RSEL_CFG);
  assign wr_tx       = wr && (sel == RSEL_TX);
  assign start       = wr_tx && ready;
  assign unused_bits = ^{wdata, addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en   <= '0;
      presc   <= '0;
      len_q   <= 1'b0;
      cpha    <= 1'b0;
      cpol    <= 1'b0;
      queue_q <= 1'b0;
      flush_q <= 1'b0;
      tx_byte <= '0;
      din_q   <= '0;
    end else begin
      if (wr_ctrl)
        cs_en <= wdata[BIT_CS0 +: NUM_CS];
      if (wr_cfg) begin
        presc   <= wdata[PRESC_W-1:0];
        len_q   <= wdata[BIT_LEN];
        cpha    <= wdata[BIT_PHA];
        cpol    <= wdata[BIT_POL];
        queue_q <= wdata[BIT_QUEUE];
      end
      // no queue is kept, so a flush completes in one cycle
      flush_q <= wr_cfg && wdata[BIT_FLUSH];
      if (start)
        tx_byte <= wdata[BYTE_W-1:0];
      if (done)
        din_q <= rx_byte;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      RSEL_CTRL: begin
        rdata[BIT_READY]         = ready;
        rdata[BIT_CS0 +: NUM_CS] = cs_en;
      end
      RSEL_CFG: begin
        rdata[PRESC_W-1:0] = presc;
        rdata[BIT_LEN]     = len_q;
        rdata[BIT_PHA]     = cpha;
        rdata[BIT_POL]     = cpol;
        rdata[BIT_FLUSH]   = flush_q;
        rdata[BIT_QUEUE]   = queue_q;
      end
      RSEL_TX:  rdata[BYTE_W-1:0] = tx_byte;
      RSEL_RX:  rdata[BYTE_W-1:0] = din_q;
      default:  rdata = '0;
    endcase
  end

  // R9: the flush request is visible for one cycle only
  p_flush_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);

  // R10: a trigger while busy leaves the accepted byte alone
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !ready) |=> $stable(tx_byte));

  // R10: receive word changes only on completion
  p_din_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(din_q));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int PRESC_W = 5,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  logic               start, busy, done, ready;
  logic               lead_tick, trail_tick;
  logic               cpol, cpha;
  logic [PRESC_W-1:0] presc;
  logic [BYTE_W-1:0]  tx_byte, rx_byte;
  logic [NUM_CS-1:0]  cs_en;

  assign ready    = !busy;
  assign spi_cs_n = ~cs_en;

  spi_lm_regs #(
    .NUM_CS (NUM_CS),
    .PRESC_W(PRESC_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ready  (ready),
    .done   (done),
    .rx_byte(rx_byte),
    .start  (start),
    .tx_byte(tx_byte),
    .presc  (presc),
    .cpol   (cpol),
    .cpha   (cpha),
    .cs_en  (cs_en)
  );

  spi_lm_clkgen #(
    .PRESC_W(PRESC_W)
  ) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (busy),
    .div_in    (presc),
    .lead_tick (lead_tick),
    .trail_tick(trail_tick)
  );

  spi_lm_shifter #(
    .BITS(BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_in     (tx_byte_next(reg_wdata)),
    .cpol_cfg  (cpol),
    .cpha_cfg  (cpha),
    .lead_tick (lead_tick),
    .trail_tick(trail_tick),
    .miso      (spi_miso),
    .busy      (busy),
    .done      (done),
    .rx_out    (rx_byte),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi)
  );

  function automatic logic [BYTE_W-1:0] tx_byte_next(input logic [31:0] w);
    return w[BYTE_W-1:0];
  endfunction

  // R3: select line n follows its enable bit (one cycle after the write)
  p_cs_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[3:2] == 2'd0) |=>
      (spi_cs_n == ~$past(reg_wdata[BIT_CS0 +: NUM_CS])));

  logic unused_txb;
  assign unused_txb = ^tx_byte;

endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;

  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int n_run = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  // slave model
  logic       tb_cpol = 1'b0, tb_cpha = 1'b0, slave_on = 1'b0;
  logic [7:0] s_tx = '0, s_rx = '0;
  logic       s_hold = 1'b0;
  int         s_lead = 0;

  always #5 clk = ~clk;

  spi_byte_master #(.NUM_CS(NCS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  assign spi_miso = tb_cpha ? s_hold : s_tx[7];

  always @(spi_sclk) begin
    if (slave_on && !(&spi_cs_n)) begin
      if (spi_sclk !== tb_cpol) begin
        s_lead++;
        if (!tb_cpha) s_rx = {s_rx[6:0], spi_mosi};
        else begin s_hold = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
      end else begin
        if (!tb_cpha) s_tx = {s_tx[6:0], 1'b0};
        else s_rx = {s_rx[6:0], spi_mosi};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
    reg_wr = 1'b0; reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input int presc);
    logic [31:0] v;
    tb_cpol = pol; tb_cpha = pha;
    wr(4'h4, (32'(pol) << 7) | (32'(pha) << 6) | 32'(presc));
    chk("R7 idle clock level", 32'(spi_sclk), 32'(pol));
    rd_now(4'h4, v);
    chk("R2 cfg readback", v, (32'(pol) << 7) | (32'(pha) << 6) | 32'(presc));
  endtask

  // one exchange; ign_at >= 0 places a dropped trigger at that poll point
  task automatic run_xfer(input string nm, input logic [7:0] mb, input logic [7:0] sb,
                          input int dv, input int ign_at, input logic [7:0] prev_din);
    int hi = dv - dv / 2;
    int k = 0;
    int act_n = 0;
    logic [31:0] v;
    s_tx = sb; s_rx = '0; s_hold = 1'b0; s_lead = 0;
    wr(4'h8, {24'hA5A5A5, mb});
    forever begin
      reg_wr = 1'b0;
      reg_addr = (k == 1) ? 4'hC : 4'h0;
      #1;
      if (k == 1) chk({"R10 din held mid-exchange ", nm}, reg_rdata, 32'(prev_din));
      else if (reg_rdata[1]) break;
      if (spi_sclk !== tb_cpol) act_n++;
      if (k == ign_at) begin reg_addr = 4'h8; reg_wdata = 32'h0000_00C3; reg_wr = 1'b1; end
      @(negedge clk);
      k++;
      if (k > 4000) break;
    end
    reg_wr = 1'b0;
    chk({"R4 ready-low length ", nm}, 32'(k), 32'(8 * dv));
    chk({"R6 active clock cycles ", nm}, 32'(act_n), 32'(8 * hi));
    chk({"R8 leading edges ", nm}, 32'(s_lead), 32'd8);
    chk({"R5 slave received MSB first ", nm}, 32'(s_rx), 32'(mb));
    rd_now(4'hC, v);
    chk({"R5 din captured ", nm}, v, 32'(sb));
    rd_now(4'h8, v);
    chk({"R10 tx readback ", nm}, v, 32'(mb));
    chk({"R7 idle after ", nm}, 32'(spi_sclk), 32'(tb_cpol));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_now(4'h0, v); chk("R1 ctrl reset", v, 32'h2);
    rd_now(4'h4, v); chk("R1 cfg reset", v, 32'h0);
    rd_now(4'h8, v); chk("R1 tx reset", v, 32'h0);
    rd_now(4'hC, v); chk("R1 rx reset", v, 32'h0);
    chk("R1 selects high", 32'(spi_cs_n), 32'hF);
    chk("R1 sclk low", 32'(spi_sclk), 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'h0, 32'h0004_0000);
    chk("R3 select 2 low", 32'(spi_cs_n), 32'hB);
    rd_now(4'h0, v); chk("R3 ctrl readback, ready read-only", v, 32'h0004_0002);
    wr(4'h0, 32'h0009_0000);
    chk("R3 selects 0 and 3", 32'(spi_cs_n), 32'h6);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); chk("R2 cfg field mask", v, 32'h0002_00FF);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    wr(4'h4, 32'h0000_0203);
    rd_now(4'h4, v); chk("R9 flush visible one cycle", v, 32'h0000_0203);
    rd(4'h4, v);     chk("R9 flush self-cleared", v, 32'h0000_0003);
  endtask

  task automatic t_modes();
    slave_on = 1'b1;
    wr(4'h0, 32'h0001_0000);
    set_mode(1'b0, 1'b0, 0);  run_xfer("mode0 div0", 8'hB4, 8'h5A, 2, -1, 8'h00);
    set_mode(1'b0, 1'b1, 1);  run_xfer("mode1 div1", 8'h81, 8'h3C, 2, -1, 8'h5A);
    set_mode(1'b1, 1'b0, 5);  run_xfer("mode2 div5", 8'h6E, 8'hC1, 5, -1, 8'h3C);
    set_mode(1'b1, 1'b1, 4);  run_xfer("mode3 div4", 8'h17, 8'hE8, 4, -1, 8'hC1);
    set_mode(1'b0, 1'b0, 31); run_xfer("mode0 div31", 8'h9D, 8'h42, 31, -1, 8'hE8);
  endtask

  task automatic t_busy_write();
    set_mode(1'b0, 1'b1, 3);
    run_xfer("R10 dropped mid-trigger", 8'h2B, 8'hD7, 3, 5, 8'h42);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    set_mode(1'b0, 1'b0, 2);
    run_xfer("R10 trigger on completion edge", 8'h71, 8'h0F, 2, 15, 8'hD7);
    for (int i = 0; i < 3; i++) begin
      rd(4'h0, v);
      chk("R10 no retrigger after completion", 32'(v[1]), 32'h1);
      chk("R10 clock idle after collision", 32'(spi_sclk), 32'h0);
    end
    rd_now(4'hC, v); chk("R10 din keeps first byte", v, 32'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_flush();
    t_modes();
    t_busy_write();
    t_collision();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule